// File: doc/BRIEF.md
# Quadrature Encoder Channel with Capture Status

This block turns the two phase signals of an incremental encoder or handwheel into a signed position count. It looks at the phases only on cycles where the sample enable is high. Any step that changes both phases at once is treated as a fault: it is not counted, and it sets a sticky error that only a counter reset clears. The block also records how many sample periods passed between the two most recent counts. It raises a match output whenever the count equals a compare value supplied from outside.

Two capture sources copy the current count into a capture register. The first is a rising index pulse seen while both phases are low, called the gated index. The second is a rising home flag. A capture also stores the three commutation flags, and it sets read-to-clear flags that record that a capture happened and whether the gated index caused it. A 24-bit status word combines these sticky flags with the live levels of the encoder pins and the nine general flag pins. Software reads it together with the position, capture and interval outputs, and pulses a read strobe after taking the capture register.

Top module: `qenc_channel`

## Requirements
- R1: On each cycle with `samp_en` high, a phase pair {A,B} that moves one step along 00→10→11→01→00 adds one to `pos_cnt`, and a single step against that order subtracts one (four counts per phase cycle). The count wraps modulo 2^PW. With `samp_en` low the count holds whatever the phases do.
- R2: A sample in which A and B both differ from the previous sample does not change the count and sets status bit 8. Bit 8 stays set until `cnt_reset`. `cnt_reset` clears the count and bit 8 and takes priority over any step in the same cycle.
- R3: A sampled rising edge of `enc_idx` taken while A=B=0 (gated index), or a sampled rising edge of `flag_in[1]` (home), copies the count held before that sample into `cap_pos`. It also copies {U,V,W} = {`flag_in[7]`,`flag_in[6]`,`flag_in[5]`} into status bits 2..0 (U at bit 2). Either source sets status bit 11. Only the gated index sets status bit 10.
- R4: A `rd_cap` pulse clears status bits 10 and 11. If a capture happens in the same cycle, the capture wins and the flags end up set.
- R5: `interval` holds the number of samples from one counted step to the next: two steps in back-to-back samples give 1. The value saturates at 2^TW−1, and the running count of samples between steps does not wrap. Uncounted steps (illegal, or blocked by reset) do not end an interval.
- R6: `cmp_eq` is high exactly when `pos_cnt` equals `cmp_val`, and status bit 9 shows the same value.
- R7: Status bits 12, 13 and 14 show the live A, B and ungated index levels. Bits 23..15 show `flag_in[8:0]` (fault, home, positive limit, negative limit, user, W, V, U, T, from bit 15 upward). Bits 7..3 read as zero.
- R8: After reset, the count, the capture register, the interval, the hall field and all sticky flags are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| samp_en | input | 1 | Sample-clock enable for phases and triggers |
| cnt_reset | input | 1 | Clears count and encoder error |
| enc_a | input | 1 | Phase A |
| enc_b | input | 1 | Phase B |
| enc_idx | input | 1 | Index pulse |
| flag_in | input | 9 | Flags: [0] fault, [1] home, [2] +limit, [3] −limit, [4] user, [5] W, [6] V, [7] U, [8] T |
| rd_cap | input | 1 | Read strobe of the capture register |
| cmp_val | input | PW | Compare value |
| pos_cnt | output | PW | Position count |
| cap_pos | output | PW | Captured position |
| interval | output | TW | Samples between the last two counts |
| cmp_eq | output | 1 | Count equals compare value |
| status | output | 24 | Packed status word |

## Verification
The bench aims at the cases a decoder most often gets wrong. A double-phase jump that got counted would move the position and miss the error. An error cleared by an ordinary step instead of a counter reset would drop bit 8 too early. A read strobe that landed on a capture and cleared the new flag would lose that capture. A capture that took the already-updated count would be off by one, and an index pulse outside the A=B=0 state that set the gated flag would be wrong as well. Long idle spells check that the interval stops at its maximum and does not wrap to a small value. Random motion with occasional disabled samples checks that the count moves only on enabled cycles.

// File: rtl/qenc_pkg.sv
package qenc_pkg;
   typedef logic [1:0] ab_t;

   localparam int STAT_W   = 24;
   localparam int FLAG_N   = 9;
   localparam int HALL_N   = 3;
   localparam int B_ERR    = 8;
   localparam int B_EQ     = 9;
   localparam int B_GATED  = 10;
   localparam int B_ANY    = 11;

   // next phase pair in the counting-up direction
   function automatic ab_t ab_fwd(input ab_t s);
      case (s)
         2'b00:   ab_fwd = 2'b10;
         2'b10:   ab_fwd = 2'b11;
         2'b11:   ab_fwd = 2'b01;
         default: ab_fwd = 2'b00;
      endcase
   endfunction
endpackage

// File: rtl/qenc_decode.sv
module qenc_decode
   import qenc_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic samp_en,
   input  ab_t  ab_now,
   output logic step_up,
   output logic step_dn,
   output logic bad_step,
   output ab_t  ab_last
);
   always_ff @(posedge clk) begin
      if (!rst_n)       ab_last <= 2'b00;
      else if (samp_en) ab_last <= ab_now;
   end

   always_comb begin
      step_up  = samp_en && (ab_now == ab_fwd(ab_last));
      step_dn  = samp_en && (ab_last == ab_fwd(ab_now));
      bad_step = samp_en && ((ab_now ^ ab_last) == 2'b11);
   end
endmodule

// File: rtl/qenc_interval.sv
module qenc_interval #(
   parameter int TW       = 8,
   parameter bit SATURATE = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          samp_en,
   input  logic          edge_seen,
   output logic [TW-1:0] interval
);
   localparam logic [TW-1:0] T_TOP = '1;
   localparam logic [TW-1:0] T_ONE = TW'(1);

   logic [TW-1:0] run_cnt;
   logic [TW-1:0] run_inc;

   generate
      if (SATURATE) begin : g_sat
         assign run_inc = (run_cnt == T_TOP) ? T_TOP : run_cnt + T_ONE;
      end else begin : g_wrap
         assign run_inc = run_cnt + T_ONE;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         run_cnt  <= '0;
         interval <= '0;
      end else if (samp_en) begin
         if (edge_seen) begin
            interval <= run_inc;
            run_cnt  <= '0;
         end else begin
            run_cnt  <= run_inc;
         end
      end
   end
endmodule

// File: rtl/qenc_capture.sv
module qenc_capture
   import qenc_pkg::*;
#(
   parameter int PW = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              samp_en,
   input  logic              idx_now,
   input  logic              home_now,
   input  ab_t               ab_now,
   input  logic [PW-1:0]     pos_now,
   input  logic [HALL_N-1:0] hall_now,
   input  logic              rd_clr,
   output logic [PW-1:0]     cap_pos,
   output logic [HALL_N-1:0] hall_cap,
   output logic              flag_any,
   output logic              flag_gated,
   output logic              cap_evt
);
   logic idx_last, home_last;
   logic idx_hit, home_hit;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         idx_last  <= 1'b0;
         home_last <= 1'b0;
      end else if (samp_en) begin
         idx_last  <= idx_now;
         home_last <= home_now;
      end
   end

   always_comb begin
      idx_hit  = samp_en && idx_now && !idx_last && (ab_now == 2'b00);
      home_hit = samp_en && home_now && !home_last;
      cap_evt  = idx_hit || home_hit;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cap_pos    <= '0;
         hall_cap   <= '0;
         flag_any   <= 1'b0;
         flag_gated <= 1'b0;
      end else if (cap_evt) begin
         cap_pos  <= pos_now;
         hall_cap <= hall_now;
         flag_any <= 1'b1;
         if (idx_hit) flag_gated <= 1'b1;
      end else if (rd_clr) begin
         flag_any   <= 1'b0;
         flag_gated <= 1'b0;
      end
   end
endmodule

// File: rtl/qenc_channel.sv
module qenc_channel
   import qenc_pkg::*;
#(
   parameter int PW       = 16,
   parameter int TW       = 8,
   parameter bit SATURATE = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              samp_en,
   input  logic              cnt_reset,
   input  logic              enc_a,
   input  logic              enc_b,
   input  logic              enc_idx,
   input  logic [8:0]        flag_in,
   input  logic              rd_cap,
   input  logic [PW-1:0]     cmp_val,
   output logic [PW-1:0]     pos_cnt,
   output logic [PW-1:0]     cap_pos,
   output logic [TW-1:0]     interval,
   output logic              cmp_eq,
   output logic [23:0]       status
);
   localparam logic [PW-1:0] P_ONE = PW'(1);

   generate
      if (PW < 2) begin : g_bad_pw
         $error("qenc_channel: PW must be at least 2");
      end
      if (TW < 2) begin : g_bad_tw
         $error("qenc_channel: TW must be at least 2");
      end
   endgenerate

   ab_t ab_now, ab_last;
   logic step_up, step_dn, bad_step, edge_seen;
   logic enc_err, flag_any, flag_gated, cap_evt;
   logic [HALL_N-1:0] hall_cap, hall_now;

   assign ab_now   = {enc_a, enc_b};
   assign hall_now = {flag_in[7], flag_in[6], flag_in[5]};

   qenc_decode u_dec (
      .clk(clk), .rst_n(rst_n), .samp_en(samp_en), .ab_now(ab_now),
      .step_up(step_up), .step_dn(step_dn), .bad_step(bad_step), .ab_last(ab_last)
   );

   always_ff @(posedge clk) begin
      if (!rst_n || cnt_reset) begin
         pos_cnt <= '0;
         enc_err <= 1'b0;
      end else begin
         if (step_up)      pos_cnt <= pos_cnt + P_ONE;
         else if (step_dn) pos_cnt <= pos_cnt - P_ONE;
         if (bad_step)     enc_err <= 1'b1;
      end
   end

   assign edge_seen = (step_up || step_dn) && !cnt_reset;

   qenc_interval #(.TW(TW), .SATURATE(SATURATE)) u_ivl (
      .clk(clk), .rst_n(rst_n), .samp_en(samp_en), .edge_seen(edge_seen),
      .interval(interval)
   );

   qenc_capture #(.PW(PW)) u_cap (
      .clk(clk), .rst_n(rst_n), .samp_en(samp_en), .idx_now(enc_idx),
      .home_now(flag_in[1]), .ab_now(ab_now), .pos_now(pos_cnt),
      .hall_now(hall_now), .rd_clr(rd_cap), .cap_pos(cap_pos),
      .hall_cap(hall_cap), .flag_any(flag_any), .flag_gated(flag_gated),
      .cap_evt(cap_evt)
   );

   assign cmp_eq = (pos_cnt == cmp_val);

   assign status = {flag_in, enc_idx, enc_b, enc_a, flag_any, flag_gated,
                    cmp_eq, enc_err, 5'b00000, hall_cap};
endmodule

// File: rtl/qenc_channel_chk.sv
module qenc_channel_chk
   import qenc_pkg::*;
#(
   parameter int PW = 16
) (
   input logic          clk,
   input logic          rst_n,
   input logic          samp_en,
   input logic          cnt_reset,
   input logic          enc_a,
   input logic          enc_b,
   input logic          rd_cap,
   input logic [PW-1:0] pos_cnt,
   input logic [PW-1:0] cap_pos,
   input logic [23:0]   status,
   input ab_t           ab_last,
   input logic          cap_evt
);
   assert_err_set_R2: assert property (@(posedge clk) disable iff (!rst_n)
      samp_en && !cnt_reset && (({enc_a, enc_b} ^ ab_last) == 2'b11) |=> status[B_ERR]);

   assert_err_sticky_R2: assert property (@(posedge clk) disable iff (!rst_n)
      status[B_ERR] && !cnt_reset |=> status[B_ERR]);

   assert_cnt_clear_R2: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_reset |=> (pos_cnt == '0) && !status[B_ERR]);

   assert_hold_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
      !samp_en && !cnt_reset |=> $stable(pos_cnt));

   assert_read_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
      rd_cap && !cap_evt |=> !status[B_ANY] && !status[B_GATED]);

   assert_capture_wins_R4: assert property (@(posedge clk) disable iff (!rst_n)
      cap_evt |=> status[B_ANY]);

   assert_cap_value_R3: assert property (@(posedge clk) disable iff (!rst_n)
      cap_evt |=> cap_pos == $past(pos_cnt));

   assert_gated_implies_any_R3: assert property (@(posedge clk) disable iff (!rst_n)
      status[B_GATED] |-> status[B_ANY]);

   assert_zero_field_R7: assert property (@(posedge clk) disable iff (!rst_n)
      status[7:3] == 5'b00000);
endmodule

bind qenc_channel qenc_channel_chk #(.PW(PW)) u_chk (
   .clk(clk), .rst_n(rst_n), .samp_en(samp_en), .cnt_reset(cnt_reset),
   .enc_a(enc_a), .enc_b(enc_b), .rd_cap(rd_cap), .pos_cnt(pos_cnt),
   .cap_pos(cap_pos), .status(status), .ab_last(ab_last), .cap_evt(cap_evt)
);

// File: tb/qenc_channel_tb.sv
`timescale 1ns/1ps
module qenc_channel_tb_top;
   localparam int PW = 16;
   localparam int TW = 8;
   localparam logic [TW-1:0] T_MAX = '1;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic samp_en = 1'b0, cnt_reset = 1'b0, enc_a = 1'b0, enc_b = 1'b0, enc_idx = 1'b0;
   logic [8:0] flag_in = '0;
   logic rd_cap = 1'b0;
   logic [PW-1:0] cmp_val = '0;
   logic [PW-1:0] pos_cnt, cap_pos;
   logic [TW-1:0] interval;
   logic cmp_eq;
   logic [23:0] status;

   int total = 0, bad = 0;
   bit done = 1'b0;

   // model state
   logic [PW-1:0] m_pos = '0, m_cap = '0;
   logic [1:0] m_ab = 2'b00;
   logic m_idx = 1'b0, m_home = 1'b0, m_err = 1'b0, m_any = 1'b0, m_gated = 1'b0;
   logic [2:0] m_hall = '0;
   logic [TW-1:0] m_run = '0, m_int = '0;

   always #2.5 clk = ~clk;

   qenc_channel #(.PW(PW), .TW(TW)) dut_i (
      .clk(clk), .rst_n(rst_n), .samp_en(samp_en), .cnt_reset(cnt_reset),
      .enc_a(enc_a), .enc_b(enc_b), .enc_idx(enc_idx), .flag_in(flag_in),
      .rd_cap(rd_cap), .cmp_val(cmp_val), .pos_cnt(pos_cnt), .cap_pos(cap_pos),
      .interval(interval), .cmp_eq(cmp_eq), .status(status)
   );

   function automatic logic [1:0] fwd(input logic [1:0] s);
      case (s)
         2'b00: return 2'b10;
         2'b10: return 2'b11;
         2'b11: return 2'b01;
         default: return 2'b00;
      endcase
   endfunction

   function automatic logic [TW-1:0] sat_inc(input logic [TW-1:0] v);
      return (v == T_MAX) ? T_MAX : v + TW'(1);
   endfunction

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
      end
   endtask

   task automatic check_all();
      chk("R1 pos_cnt", 32'(pos_cnt), 32'(m_pos));
      chk("R2 error bit", 32'(status[8]), 32'(m_err));
      chk("R3 cap_pos/hall", {13'(cap_pos), status[2:0]}, {13'(m_cap), m_hall});
      chk("R4 capture flags", 32'(status[11:10]), {30'd0, m_any, m_gated});
      chk("R5 interval", 32'(interval), 32'(m_int));
      chk("R6 cmp_eq/bit9", {30'd0, cmp_eq, status[9]},
          {30'd0, m_pos == cmp_val, m_pos == cmp_val});
      chk("R7 raw/zero bits", {8'd0, status[23:12], status[7:3]},
          {8'd0, flag_in, enc_idx, enc_b, enc_a, 5'd0});
   endtask

   // one clock: drive at falling edge, update model, sample after rising edge
   task automatic step(input logic [1:0] ab, input logic idx, input logic [8:0] fl,
                       input logic se, input logic cr, input logic rd,
                       input logic [PW-1:0] cv);
      logic up, dn, ill, ihit, hhit;
      @(negedge clk);
      {enc_a, enc_b} = ab; enc_idx = idx; flag_in = fl; samp_en = se;
      cnt_reset = cr; rd_cap = rd; cmp_val = cv;
      up   = se && (ab == fwd(m_ab));
      dn   = se && (m_ab == fwd(ab));
      ill  = se && ((ab ^ m_ab) == 2'b11);
      ihit = se && idx && !m_idx && (ab == 2'b00);
      hhit = se && fl[1] && !m_home;
      if (ihit || hhit) begin
         m_cap = m_pos; m_hall = {fl[7], fl[6], fl[5]}; m_any = 1'b1;
         if (ihit) m_gated = 1'b1;
      end else if (rd) begin
         m_any = 1'b0; m_gated = 1'b0;
      end
      if (se) begin
         if ((up || dn) && !cr) begin m_int = sat_inc(m_run); m_run = '0; end
         else m_run = sat_inc(m_run);
         m_ab = ab; m_idx = idx; m_home = fl[1];
      end
      if (cr) begin m_pos = '0; m_err = 1'b0; end
      else begin
         if (up) m_pos = m_pos + PW'(1);
         else if (dn) m_pos = m_pos - PW'(1);
         if (ill) m_err = 1'b1;
      end
      @(posedge clk); #1;
      check_all();
   endtask

   initial begin
      #(5.0 * 150000);
      if (!done) begin
         total++; bad++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      logic [1:0] ab;
      void'($urandom(32'd4321));
      repeat (3) @(posedge clk);
      @(negedge clk); rst_n = 1'b1;
      #1;
      // R8: reset state
      chk("R8 reset pos", 32'(pos_cnt), 0);
      chk("R8 reset cap", 32'(cap_pos), 0);
      chk("R8 reset interval", 32'(interval), 0);
      chk("R8 reset status", 32'(status[11:0]), 32'h200);

      // R1: four up steps, four down steps
      ab = 2'b00;
      for (int i = 0; i < 4; i++) begin ab = fwd(ab); step(ab, 0, 0, 1, 0, 0, 16'd4); end
      chk("R1 after four up", 32'(pos_cnt), 4);
      for (int i = 0; i < 4; i++) begin ab = {ab[0], ~ab[1]}; step(ab, 0, 0, 1, 0, 0, 16'd0); end
      chk("R1 after four down", 32'(pos_cnt), 0);
      // R1: wrap below zero and ignore while disabled
      step(2'b01, 0, 0, 1, 0, 0, 16'hFFFF);
      step(2'b11, 0, 0, 0, 0, 0, 16'hFFFF);
      step(2'b01, 0, 0, 0, 0, 0, 16'hFFFF);
      chk("R1 wrap/idle", 32'(pos_cnt), 32'hFFFF);
      step(2'b00, 0, 0, 1, 0, 0, 16'h0);
      // R2: illegal jump then sticky error, reset clears with priority
      step(2'b11, 0, 0, 1, 0, 0, 16'h0);
      chk("R2 illegal not counted", 32'(pos_cnt), 0);
      step(2'b01, 0, 0, 1, 0, 0, 16'h0);
      chk("R2 error stays", 32'(status[8]), 1);
      step(2'b00, 0, 0, 1, 1, 0, 16'h0);
      chk("R2 reset clears", {31'd0, status[8]}, 0);
      // R5: saturation over a long idle spell
      step(2'b10, 0, 0, 1, 0, 0, 16'h0);
      for (int i = 0; i < 300; i++) step(2'b10, 0, 0, 1, 0, 0, 16'h0);
      step(2'b11, 0, 0, 1, 0, 0, 16'h0);
      chk("R5 saturated interval", 32'(interval), 32'(T_MAX));
      step(2'b01, 0, 0, 1, 0, 0, 16'h0);
      chk("R5 back-to-back interval", 32'(interval), 1);
      step(2'b00, 0, 0, 1, 0, 0, 16'h0);
      // R3/R4: gated index with read in same cycle, capture wins
      step(2'b00, 1, 9'h0E0, 1, 0, 1, 16'h0);
      chk("R4 capture beats read", 32'(status[11:10]), 3);
      chk("R3 hall captured", 32'(status[2:0]), 7);
      step(2'b00, 0, 0, 1, 0, 1, 16'h0);
      chk("R4 read clears", 32'(status[11:10]), 0);
      // R3: index outside 00 does not capture; home sets only bit 11
      step(2'b10, 0, 0, 1, 0, 0, 16'h0);
      step(2'b10, 1, 0, 1, 0, 0, 16'h0);
      chk("R3 ungated index ignored", 32'(status[11:10]), 0);
      step(2'b10, 0, 9'h002, 1, 0, 0, 16'h0);
      chk("R3 home capture", 32'(status[11:10]), 2);

      // random phase
      for (int i = 0; i < 3000; i++) begin
         logic [3:0] r;
         logic se;
         logic [PW-1:0] cv;
         r  = 4'($urandom % 16);
         se = ($urandom % 4) != 0;
         ab = m_ab;
         if (se) begin
            if (r < 6) ab = fwd(m_ab);
            else if (r < 12) ab = {m_ab[0], ~m_ab[1]};
            else if (r == 15) ab = ~m_ab;
         end
         cv = ($urandom % 2) ? m_pos + PW'($urandom % 3) - PW'(1) : PW'($urandom);
         step(ab, ($urandom % 4) == 0, 9'($urandom), se,
              ($urandom % 64) == 0, ($urandom % 8) == 0, cv);
      end

      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule